// File: doc/BRIEF.md
# Matrix Multiply Engine Controller

This block multiplies two square matrices of unsigned integers, sized N x N with N a power of two (4 x 4 with 16-bit elements by default). A host streams both operand matrices in over a valid/ready input. The words go first to the A store and then to the B store, each in row-major order. The host then sets the start bit in a two-register control space. A source sequencer walks every output element (i,j) and feeds the operand pairs A[i][k] and B[k][j] to a multiply-accumulate stage, one pair per clock. A separate result writer stores each finished dot product into the result store on the cycle it appears. The writer owns its own state machine, so operand streaming for the next element never waits on write-back of the previous one. The host polls a status register for completion and reads the results through a synchronous read port.

Four small state machines make up the control. The loader moves LD_FILL_A -> LD_FILL_B after N*N accepted words. It moves LD_FILL_B -> LD_FULL after another N*N words, and LD_FULL -> LD_FILL_A when a run completes. The source sequencer moves SRC_IDLE -> SRC_STREAM on an accepted start and SRC_STREAM -> SRC_IDLE after its N*N*N-th term. The result writer moves WB_IDLE -> WB_RUN on an accepted start and WB_RUN -> WB_IDLE on its N*N-th write. The run controller moves CTL_IDLE -> CTL_RUN and CTL_DONE -> CTL_RUN on an accepted start, and CTL_RUN -> CTL_DONE on the final result write.

Top module: `mmul_engine`

## Requirements
- R1: After reset, and again after each completed run, `ld_ready` is 1. The first N*N accepted words fill A in row-major order (word r*N+c is A[r][c]) and the next N*N words fill B the same way. `ld_ready` then stays 0 until the run completes, and words offered while it is 0 change nothing.
- R2: A CSR write to address 0 with `csr_wbit`=1 starts a run only when both matrices are loaded and no run is active. A start written before the load is complete is ignored.
- R3: Result element i*N+j equals the unsigned sum over k of A[i][k]*B[k][j], kept in full in 2*DW+log2(N) bits with no wrap.
- R4: Operand pairs issue on consecutive cycles with no bubble between elements. The done status becomes visible exactly N*N*N+2 clock edges after the edge that accepted the start.
- R5: A CSR read strobe returns its data on `csr_rdata` in the cycle after the sampling edge. Address 1 gives bit0 done, bit1 busy and bit2 loaded, with all other bits 0. Address 0 reads as 0.
- R6: The done bit stays 1, including across a reload, until the next accepted start clears it.
- R7: A start written while a run is active is ignored, and the completion time of the active run does not change.
- R8: The result read port returns the element at `res_rd_addr` one cycle after the sampling edge. When a run completes, the loaded bit clears and `ld_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Operand word offered |
| ld_ready | output | 1 | Loader accepts a word |
| ld_data | input | DW | Operand word |
| csr_wr | input | 1 | CSR write strobe |
| csr_rd | input | 1 | CSR read strobe |
| csr_addr | input | 1 | CSR register select: 0 control, 1 status |
| csr_wbit | input | 1 | Write data bit (start when 1 at address 0) |
| csr_rdata | output | CSR_W | Registered CSR read data |
| res_rd_addr | input | 2*log2(N) | Result element index i*N+j |
| res_rd_data | output | 2*DW+log2(N) | Registered result read data |

## Verification
The assertions assume that `csr_wr` and `csr_rd` are never raised together, that every input is steady around the rising edge, and that reset is held for at least one edge before use. The bench drives all strobes and the load stream at the falling edge and never raises both CSR strobes at once. It inserts regular gaps in `ld_valid` so the loader's phase changes are reached both back to back and after idle cycles. Completion timing is measured while a second start and a status read are injected into the active run.

// File: rtl/mm_pkg.sv
package mm_pkg;

    // Loader phases: which operand store the next accepted word goes to.
    typedef enum logic [1:0] {
        LD_FILL_A,
        LD_FILL_B,
        LD_FULL
    } ld_state_t;

    // Source sequencer: idle or issuing one operand pair per cycle.
    typedef enum logic {
        SRC_IDLE,
        SRC_STREAM
    } src_state_t;

    // Result writer: waiting for a run or collecting dot products.
    typedef enum logic {
        WB_IDLE,
        WB_RUN
    } wb_state_t;

    // Run controller seen by software through the status register.
    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_RUN,
        CTL_DONE
    } ctl_state_t;

    // Tag travelling with each operand pair down the pipe.
    typedef struct packed {
        logic valid;
        logic first;
        logic last;
    } term_tag_t;

endpackage

// File: rtl/mm_load_ctrl.sv
module mm_load_ctrl
    import mm_pkg::*;
#(
    parameter int N_LOG = 2,
    parameter int DW    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_valid,
    input  logic [DW-1:0]        ld_data,
    input  logic                 reload,
    output logic                 ld_ready,
    output logic                 wr_a,
    output logic                 wr_b,
    output logic [2*N_LOG-1:0]   wr_addr,
    output logic [DW-1:0]        wr_data,
    output logic                 full
);
    localparam int AW = 2 * N_LOG;

    ld_state_t       state, state_nx;
    logic [AW-1:0]   idx;
    logic            fire;
    logic            idx_last;

    assign fire     = ld_valid && ld_ready;
    assign idx_last = (idx == '1);

    // Phase transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            LD_FILL_A: if (fire && idx_last) state_nx = LD_FILL_B;
            LD_FILL_B: if (fire && idx_last) state_nx = LD_FULL;
            LD_FULL:   if (reload)           state_nx = LD_FILL_A;
            default:                         state_nx = LD_FILL_A;
        endcase
    end

    // State register and word index (wraps at N*N between phases).
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LD_FILL_A;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (reload)    idx <= '0;
            else if (fire) idx <= idx + 1'b1;
        end
    end

    // Outputs decoded from the phase.
    always_comb begin
        ld_ready = 1'b0;
        wr_a     = 1'b0;
        wr_b     = 1'b0;
        full     = 1'b0;
        unique case (state)
            LD_FILL_A: begin ld_ready = 1'b1; wr_a = ld_valid; end
            LD_FILL_B: begin ld_ready = 1'b1; wr_b = ld_valid; end
            LD_FULL:   full = 1'b1;
            default:   ;
        endcase
    end

    assign wr_addr = idx;
    assign wr_data = ld_data;

    // R1: entering the full phase happens exactly on an index wrap.
    p_full_at_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> (idx == '0));

endmodule

// File: rtl/mm_src_seq.sv
module mm_src_seq
    import mm_pkg::*;
#(
    parameter int N_LOG = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output logic [2*N_LOG-1:0]   a_addr,
    output logic [2*N_LOG-1:0]   b_addr,
    output term_tag_t            tag
);
    localparam int CW = 3 * N_LOG;

    src_state_t      state, state_nx;
    logic [CW-1:0]   cnt;
    logic [N_LOG-1:0] ri, cj, kk;

    // Counter fields: row i (high), column j, term k (low).
    assign ri = cnt[3*N_LOG-1:2*N_LOG];
    assign cj = cnt[2*N_LOG-1:N_LOG];
    assign kk = cnt[N_LOG-1:0];

    always_comb begin
        state_nx = state;
        unique case (state)
            SRC_IDLE:   if (start)      state_nx = SRC_STREAM;
            SRC_STREAM: if (cnt == '1)  state_nx = SRC_IDLE;
            default:                    state_nx = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SRC_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == SRC_STREAM) cnt <= cnt + 1'b1;
            else                     cnt <= '0;
        end
    end

    // A[i][k] sits at i*N+k, B[k][j] at k*N+j.
    always_comb begin
        a_addr    = {ri, kk};
        b_addr    = {kk, cj};
        tag       = '0;
        unique case (state)
            SRC_STREAM: begin
                tag.valid = 1'b1;
                tag.first = (kk == '0);
                tag.last  = (kk == '1);
            end
            default: ;
        endcase
    end

    // R4: every term after the first of an element follows an issued term.
    p_no_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        (tag.valid && !tag.first) |-> $past(tag.valid));

endmodule

// File: rtl/mm_mac.sv
module mm_mac
    import mm_pkg::*;
#(
    parameter int N_LOG = 2,
    parameter int DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DW-1:0]              op_a,
    input  logic [DW-1:0]              op_b,
    input  term_tag_t                  tag,
    output logic                       res_valid,
    output logic [2*DW+N_LOG-1:0]      res_data
);
    localparam int PW    = 2 * DW;
    localparam int ACC_W = PW + N_LOG;

    logic [PW-1:0]    prod;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;

    // The first term restarts the sum, so elements run back to back.
    always_comb begin
        prod = op_a * op_b;
        sum  = (tag.first ? '0 : acc) + ACC_W'(prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= tag.valid && tag.last;
            if (tag.valid) acc <= sum;
            if (tag.valid && tag.last) res_data <= sum;
        end
    end

    // R3: the accumulator never wraps.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        tag.valid |-> (sum >= ACC_W'(prod)));

    // R4: with N > 1 finished sums are at least N cycles apart.
    generate
        if (N_LOG > 0) begin : g_spacing
            p_result_spacing_r4: assert property (@(posedge clk) disable iff (rst)
                res_valid |=> !res_valid);
        end
    endgenerate

endmodule

// File: rtl/mm_res_wb.sv
module mm_res_wb
    import mm_pkg::*;
#(
    parameter int N_LOG = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 in_valid,
    output logic                 wr_en,
    output logic [2*N_LOG-1:0]   wr_addr,
    output logic                 final_wr
);
    localparam int AW = 2 * N_LOG;

    wb_state_t     state, state_nx;
    logic [AW-1:0] idx;

    always_comb begin
        state_nx = state;
        unique case (state)
            WB_IDLE: if (start)                  state_nx = WB_RUN;
            WB_RUN:  if (in_valid && idx == '1)  state_nx = WB_IDLE;
            default:                             state_nx = WB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WB_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == WB_IDLE)  idx <= '0;
            else if (in_valid)     idx <= idx + 1'b1;
        end
    end

    always_comb begin
        wr_en    = 1'b0;
        final_wr = 1'b0;
        unique case (state)
            WB_RUN: begin
                wr_en    = in_valid;
                final_wr = in_valid && (idx == '1);
            end
            default: ;
        endcase
    end

    assign wr_addr = idx;

    // R3: sums only arrive while the writer is collecting a run.
    p_sum_while_running_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (state == WB_RUN));

endmodule

// File: rtl/mmul_engine.sv
module mmul_engine
    import mm_pkg::*;
#(
    parameter int N_LOG = 2,
    parameter int DW    = 16,
    parameter int CSR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ld_valid,
    output logic                       ld_ready,
    input  logic [DW-1:0]              ld_data,
    input  logic                       csr_wr,
    input  logic                       csr_rd,
    input  logic                       csr_addr,
    input  logic                       csr_wbit,
    output logic [CSR_W-1:0]           csr_rdata,
    input  logic [2*N_LOG-1:0]         res_rd_addr,
    output logic [2*DW+N_LOG-1:0]      res_rd_data
);
    localparam int AW    = 2 * N_LOG;
    localparam int ELEMS = 1 << AW;
    localparam int ACC_W = 2 * DW + N_LOG;

    // ---------------- loader ----------------
    logic          wr_a, wr_b, loaded, final_wr;
    logic [AW-1:0] ld_addr;
    logic [DW-1:0] ld_wdata;

    mm_load_ctrl #(.N_LOG(N_LOG), .DW(DW)) u_load (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .ld_data  (ld_data),
        .reload   (final_wr),
        .ld_ready (ld_ready),
        .wr_a     (wr_a),
        .wr_b     (wr_b),
        .wr_addr  (ld_addr),
        .wr_data  (ld_wdata),
        .full     (loaded)
    );

    logic [DW-1:0]    mem_a [ELEMS];
    logic [DW-1:0]    mem_b [ELEMS];
    logic [ACC_W-1:0] mem_r [ELEMS];

    always_ff @(posedge clk) begin
        if (wr_a) mem_a[ld_addr] <= ld_wdata;
        if (wr_b) mem_b[ld_addr] <= ld_wdata;
    end

    // ---------------- run control ----------------
    ctl_state_t ctl_state, ctl_nx;
    logic       start_req, start_go;
    logic       st_done, st_busy;

    assign start_req = csr_wr && (csr_addr == 1'b0) && csr_wbit;
    assign start_go  = start_req && loaded && (ctl_state != CTL_RUN);

    always_comb begin
        ctl_nx = ctl_state;
        unique case (ctl_state)
            CTL_IDLE: if (start_go) ctl_nx = CTL_RUN;
            CTL_RUN:  if (final_wr) ctl_nx = CTL_DONE;
            CTL_DONE: if (start_go) ctl_nx = CTL_RUN;
            default:                ctl_nx = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_state <= CTL_IDLE;
        else     ctl_state <= ctl_nx;
    end

    always_comb begin
        st_done = 1'b0;
        st_busy = 1'b0;
        unique case (ctl_state)
            CTL_RUN:  st_busy = 1'b1;
            CTL_DONE: st_done = 1'b1;
            default:  ;
        endcase
    end

    // Registered CSR read.
    always_ff @(posedge clk) begin
        if (rst) begin
            csr_rdata <= '0;
        end else if (csr_rd) begin
            csr_rdata <= '0;
            if (csr_addr) begin
                csr_rdata[0] <= st_done;
                csr_rdata[1] <= st_busy;
                csr_rdata[2] <= loaded;
            end
        end
    end

    // ---------------- source side ----------------
    logic [AW-1:0] a_addr, b_addr;
    term_tag_t     src_tag, tag_q;
    logic [DW-1:0] a_q, b_q;

    mm_src_seq #(.N_LOG(N_LOG)) u_src (
        .clk    (clk),
        .rst    (rst),
        .start  (start_go),
        .a_addr (a_addr),
        .b_addr (b_addr),
        .tag    (src_tag)
    );

    always_ff @(posedge clk) begin
        a_q <= mem_a[a_addr];
        b_q <= mem_b[b_addr];
        if (rst) tag_q <= '0;
        else     tag_q <= src_tag;
    end

    logic             mac_valid;
    logic [ACC_W-1:0] mac_data;

    mm_mac #(.N_LOG(N_LOG), .DW(DW)) u_mac (
        .clk       (clk),
        .rst       (rst),
        .op_a      (a_q),
        .op_b      (b_q),
        .tag       (tag_q),
        .res_valid (mac_valid),
        .res_data  (mac_data)
    );

    // ---------------- result side ----------------
    logic          res_we;
    logic [AW-1:0] res_waddr;

    mm_res_wb #(.N_LOG(N_LOG)) u_wb (
        .clk      (clk),
        .rst      (rst),
        .start    (start_go),
        .in_valid (mac_valid),
        .wr_en    (res_we),
        .wr_addr  (res_waddr),
        .final_wr (final_wr)
    );

    always_ff @(posedge clk) begin
        if (res_we) mem_r[res_waddr] <= mac_data;
        res_rd_data <= mem_r[res_rd_addr];
    end

    // R1: the loader holds its input closed for the whole run.
    p_load_closed_busy_r1: assert property (@(posedge clk) disable iff (rst)
        st_busy |-> !ld_ready);

    // R6: completion only ever follows an active run.
    p_done_after_run_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_done) |-> $past(st_busy));

    // R7: a start during a run does not disturb it.
    p_start_ignored_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (st_busy && start_req && !final_wr) |=> st_busy);

    // R2: a run begins only with both matrices present.
    p_start_needs_load_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(st_busy) |-> $past(loaded));

endmodule

// File: tb/mmul_engine_tb_top.sv
`timescale 1ns/1ps
module mmul_engine_tb_top;
    localparam int NL    = 2;
    localparam int N     = 4;
    localparam int DW    = 16;
    localparam int E     = N * N;
    localparam int ACC_W = 2 * DW + NL;
    localparam int RUN_CYC = N * N * N + 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst = 1'b1;
    logic             ld_valid = 1'b0;
    logic             ld_ready;
    logic [DW-1:0]    ld_data = '0;
    logic             csr_wr = 1'b0;
    logic             csr_rd = 1'b0;
    logic             csr_addr = 1'b0;
    logic             csr_wbit = 1'b0;
    logic [7:0]       csr_rdata;
    logic [2*NL-1:0]  res_rd_addr = '0;
    logic [ACC_W-1:0] res_rd_data;

    mmul_engine #(.N_LOG(NL), .DW(DW), .CSR_W(8)) dut_i (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
        .csr_wbit(csr_wbit), .csr_rdata(csr_rdata),
        .res_rd_addr(res_rd_addr), .res_rd_data(res_rd_data)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [DW-1:0] ma [E];
    logic [DW-1:0] mb [E];

    function automatic logic [DW-1:0] gen(input int p, input int m, input int r, input int c);
        int unsigned h;
        case (p)
            0: return '0;
            1: return (m == 0) ? DW'(r == c) : DW'(r * N + c + 1);
            2: return '1;
            3: return (m == 0) ? DW'(r * N + c) : DW'(16'h0100 + c * N + r);
            4: begin
                h = (r * N + c + 16 * m + 1) * 32'h9E37_79B1;
                return h[31:16];
            end
            default: return (m == 1) ? DW'(r == c) : DW'(16'hF000 + r * 16 + c);
        endcase
    endfunction

    task automatic csr_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        csr_rd = 1'b1; csr_addr = a;
        @(posedge clk);
        @(negedge clk);
        csr_rd = 1'b0;
        v = csr_rdata;
    endtask

    task automatic csr_start();
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = 1'b0; csr_wbit = 1'b1;
        @(posedge clk);
        @(negedge clk);
        csr_wr = 1'b0; csr_wbit = 1'b0;
    endtask

    task automatic load(input int p);
        int acc_n;
        int cyc;
        logic rdy;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ma[r*N+c] = gen(p, 0, r, c);
                mb[r*N+c] = gen(p, 1, r, c);
            end
        acc_n = 0;
        cyc = 0;
        while (acc_n < 2 * E) begin
            @(negedge clk);
            ld_data  = (acc_n < E) ? ma[acc_n] : mb[acc_n - E];
            ld_valid = (cyc % 5 != 3);
            rdy = ld_ready;
            @(posedge clk);
            if (ld_valid && rdy) acc_n++;
            cyc++;
        end
        // R1: further words are refused and must not reach the stores.
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            ld_valid = 1'b1;
            ld_data  = 16'hDEAD;
            chk(ld_ready == 1'b0, "R1 ready low when full", 64'(ld_ready), 64'd0);
            @(posedge clk);
        end
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic run_and_check(input int p);
        logic [7:0]  st;
        logic [63:0] exp;
        int n;
        bit seen;
        csr_read(1'b1, st);
        chk(st == ((p == 0) ? 8'h04 : 8'h05), "R5 R6 status before start", 64'(st),
            (p == 0) ? 64'h4 : 64'h5);
        // start at the next edge E0
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = 1'b0; csr_wbit = 1'b1;
        @(posedge clk);
        n = 0;
        seen = 1'b0;
        while (!seen && n < 300) begin
            @(negedge clk);
            csr_wr = 1'b0; csr_wbit = 1'b0; csr_rd = 1'b0;
            if (n == 21) chk(csr_rdata == 8'h06, "R5 status busy mid-run", 64'(csr_rdata), 64'h6);
            if (st_seen_done()) begin
                seen = 1'b1;
            end else begin
                if (n == 10 && (p % 2 == 1)) begin
                    csr_wr = 1'b1; csr_addr = 1'b0; csr_wbit = 1'b1; // R7 start while busy
                end
                if (n == 20) begin
                    csr_rd = 1'b1; csr_addr = 1'b1;
                end
                @(posedge clk);
                n++;
            end
        end
        chk(n == RUN_CYC, "R4 R7 completion latency", 64'(n), 64'(RUN_CYC));
        csr_read(1'b1, st);
        chk(st == 8'h01, "R6 R8 status after run", 64'(st), 64'h1);
        csr_read(1'b0, st);
        chk(st == 8'h00, "R5 control reads zero", 64'(st), 64'h0);
        chk(ld_ready == 1'b1, "R8 loader reopened", 64'(ld_ready), 64'd1);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                exp = '0;
                for (int k = 0; k < N; k++)
                    exp += 64'(ma[i*N+k]) * 64'(mb[k*N+j]);
                @(negedge clk);
                res_rd_addr = 4'(i * N + j);
                @(posedge clk);
                @(negedge clk);
                chk(64'(res_rd_data) == exp, "R3 R8 result element", 64'(res_rd_data), exp);
            end
    endtask

    // Done flag observed through the status register path only when idle;
    // during the run the bench reads it via a one-cycle status read.
    logic done_probe;
    function automatic bit st_seen_done();
        return done_probe;
    endfunction

    // Status read each cycle would collide with scheduled strobes, so
    // completion is tracked through the loader reopening (R8) together
    // with a status confirmation after the loop.
    always_comb done_probe = ld_ready && !ld_valid && !rst;

    initial begin
        logic [7:0] st;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(ld_ready == 1'b1, "R1 ready after reset", 64'(ld_ready), 64'd1);
        csr_read(1'b1, st);
        chk(st == 8'h00, "R5 status after reset", 64'(st), 64'h0);
        csr_start();
        csr_read(1'b1, st);
        chk(st == 8'h00, "R2 start before load ignored", 64'(st), 64'h0);
        for (int p = 0; p < 6; p++) begin
            load(p);
            run_and_check(p);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule